// File: doc/BRIEF.md
# Paired-Register I2C Slave Engine

This block is the serial front end of a 16-bit port expander. It oversamples the SCL and SDA lines with the system clock. It removes short glitches from both lines and finds START and STOP conditions. It then runs a byte-level state machine that accepts a 7-bit slave address and loads a 3-bit register pointer from a command byte. It issues single-cycle write strobes and read requests to a register bank that sits outside the block. The bank answers each read request with a byte on `rd_data`.

The eight registers form four pairs, {0,1}, {2,3}, {4,5} and {6,7}. After each data byte the pointer flips its lowest bit, so a burst moves back and forth inside one pair (7, 6, 7, ...). This holds for writes and for reads. A read uses the pointer left by an earlier write. A typical read sequence is: write the command byte, send a repeated START, then read.

The engine has eight states. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. ST_ADDR_ACK drives the address acknowledge. ST_WRX receives a command or data byte. ST_WR_ACK acknowledges a received byte. ST_TX shifts a byte out. ST_TX_ACK samples the master acknowledge. ST_HOLD waits after a NACK.

The transitions are:
- Any state goes to ST_ADDR on a START and to ST_IDLE on a STOP.
- ST_ADDR goes to ST_ADDR_ACK if the address matches, else to ST_IDLE.
- ST_ADDR_ACK goes to ST_TX for a read or to ST_WRX for a write.
- ST_WRX goes to ST_WR_ACK, and ST_WR_ACK returns to ST_WRX.
- ST_TX goes to ST_TX_ACK. ST_TX_ACK goes back to ST_TX on an ACK or to ST_HOLD on a NACK.

Top module: `i2c_pair_slave`

## Requirements
- R1: After reset, `sda_oe`, `wr_en` and `rd_req` are 0 and `reg_addr` is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before a START, bus traffic gets no acknowledge and causes no write.
- R3: The address byte is sent MSB first. Bits 7..4 must be 0100, bits 3..1 must equal `dev_sel[2:0]`, and bit 0 selects the direction (1 = read, 0 = write). The slave pulls SDA low in the ninth clock only on a match. After a mismatch it ignores the bus until the next START.
- R4: In a write, the first byte after the address is the command byte, and its bits 2..0 load the pointer (bits 7..3 are ignored). The slave acknowledges the command byte and every later data byte.
- R5: Each data byte after the command byte gives one `wr_en` pulse of one clock. During that pulse `reg_addr` holds the pointer and `wr_data` holds the byte. The pointer then flips bit 0.
- R6: On a read, `rd_req` pulses for one clock during the address acknowledge and during each master ACK, with `reg_addr` already valid. `rd_data` is taken when that acknowledge clock ends and is sent MSB first.
- R7: After each byte the master ACKs, the read pointer flips bit 0. The pointer survives STOP and repeated START.
- R8: After a master NACK the slave drives no more data and raises no `rd_req` until STOP or START.
- R9: `sda_oe` changes only while SCL is low.
- R10: Pulses on SCL or SDA shorter than `FILT_CYCLES` system clocks have no effect.
- R11: A START or STOP in the middle of a byte ends the transfer with no write for the partial byte and keeps the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_sel | input | 3 | Hardwired low address bits |
| reg_addr | output | PTR_W | Register pointer |
| wr_data | output | 8 | Write data byte |
| wr_en | output | 1 | One-cycle write strobe |
| rd_req | output | 1 | One-cycle read fetch request |
| rd_data | input | 8 | Read data from the register bank |

## Verification
Condition detection can land in the same cycle as the byte-level shift and acknowledge logic. A repeated START arrives as the rising SCL that the shifter counts as a data bit, and a STOP mid-byte lands while bits are still being collected. The bench provokes both cases. It sends a repeated START right after a command acknowledge, and a STOP after four data bits. It then judges the result at the ports: the follow-up address must be taken cleanly, no write strobe may appear for the partial byte, and a later read must show the pointer unchanged.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRX,
        ST_WR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } eng_state_t;
endpackage

// File: rtl/i2cps_filter.sv
module i2cps_filter #(
    parameter int FILT_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            cnt  <= '0;
            dout <= 1'b1;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 == dout) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                dout <= s2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10
    glitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(s2, 2) == dout));
endmodule

// File: rtl/i2cps_busev.sv
module i2cps_busev (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_pair_slave.sv
module i2c_pair_slave
    import i2cps_pkg::*;
#(
    parameter int          FILT_CYCLES = 5,
    parameter logic [3:0]  ADDR_FIXED  = 4'b0100,
    parameter int          PTR_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [2:0]       dev_sel,
    output logic [PTR_W-1:0] reg_addr,
    output logic [7:0]       wr_data,
    output logic             wr_en,
    output logic             rd_req,
    input  logic [7:0]       rd_data
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);
    localparam int NLINES = 2;

    // line conditioning: index 0 = SCL, 1 = SDA
    logic [NLINES-1:0] raw_lines, filt_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2cps_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2cps_busev u_busev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    eng_state_t       state, state_nx;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txbyte;
    logic [PTR_W-1:0] ptr;
    logic             rw_q;
    logic             first_q;
    logic             wr_pend;
    logic             mack_q;
    logic             addr_hit;

    assign addr_hit = (shreg[7:4] == ADDR_FIXED) && (shreg[3:1] == dev_sel);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && bitcnt == LAST_RX)
                                 state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_nx = rw_q ? ST_TX : ST_WRX;
                ST_WRX:      if (scl_fall && bitcnt == LAST_RX) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WRX;
                ST_TX:       if (scl_fall && bitcnt == LAST_TX) state_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_nx = mack_q ? ST_TX : ST_HOLD;
                ST_HOLD:     state_nx = ST_HOLD;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            txbyte  <= 8'hFF;
            ptr     <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            wr_pend <= 1'b0;
            mack_q  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            rd_req  <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            rd_req <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt  <= '0;
                wr_pend <= 1'b0;
                txbyte  <= 8'hFF;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (scl_fall && bitcnt == LAST_RX) begin
                            rw_q <= shreg[0];
                            if (addr_hit && shreg[0]) rd_req <= 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt  <= '0;
                            first_q <= 1'b1;
                            if (rw_q) txbyte <= rd_data;
                        end
                    end
                    ST_WRX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (scl_fall && bitcnt == LAST_RX) begin
                            if (first_q) begin
                                ptr     <= shreg[PTR_W-1:0];
                                first_q <= 1'b0;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                                wr_pend <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (wr_pend) begin
                                ptr[0]  <= ~ptr[0];
                                wr_pend <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            bitcnt <= bitcnt + 1'b1;
                            txbyte <= (bitcnt == LAST_TX) ? 8'hFF : {txbyte[6:0], 1'b1};
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                            if (!sda_f) begin
                                ptr[0] <= ~ptr[0];
                                rd_req <= 1'b1;
                            end
                        end
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (mack_q) txbyte <= rd_data;
                        end
                    end
                    ST_IDLE, ST_HOLD: ;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_TX:                  sda_oe = ~txbyte[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    assign reg_addr = ptr;

    // R9
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe));

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R7
    ptr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr) |-> $past(scl_rise || scl_fall));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (!sda_oe && !rd_req));
endmodule

// File: tb/i2c_pair_slave_tb.sv
module i2c_pair_slave_tb;
    localparam int Q = 20;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] AW = 8'h4A;
    localparam logic [7:0] AR = 8'h4B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, wr_en, rd_req;
    logic [2:0] reg_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic sda_bus;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_pair_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .dev_sel(SEL), .reg_addr(reg_addr),
        .wr_data(wr_data), .wr_en(wr_en), .rd_req(rd_req), .rd_data(rd_data)
    );

    // register bank model
    logic [7:0] mem [8];
    logic [2:0] wl_a [16];
    logic [7:0] wl_d [16];
    logic [2:0] rl_a [16];
    int wcnt = 0;
    int rcnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= 8'hC0 + 8'(i);
            rd_data <= 8'h00;
        end else begin
            if (wr_en) begin
                mem[reg_addr] <= wr_data;
                if (wcnt < 16) begin wl_a[wcnt] <= reg_addr; wl_d[wcnt] <= wr_data; end
                wcnt <= wcnt + 1;
            end
            if (rd_req) begin
                rd_data <= mem[reg_addr];
                if (rcnt < 16) rl_a[rcnt] <= reg_addr;
                rcnt <= rcnt + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; tick(Q);
        sda_m = 0; tick(Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1; tick(Q);
        scl_m = 1; tick(Q);
        sda_m = 0; tick(Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; tick(Q);
        scl_m = 1; tick(Q);
        sda_m = 1; tick(Q);
    endtask

    task automatic wbit(bit b);
        sda_m = b; tick(Q);
        scl_m = 1; tick(2 * Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic wbyte(logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        sda_m = 1; tick(Q);
        scl_m = 1; tick(Q);
        ack = !sda_bus;
        tick(Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic rbyte(bit mack, output logic [7:0] d, output bit stable);
        stable = 1;
        for (int i = 7; i >= 0; i--) begin
            logic a;
            sda_m = 1; tick(Q);
            scl_m = 1; tick(Q);
            a = sda_bus;
            tick(Q - 1);
            if (sda_bus !== a) stable = 0;
            d[i] = a;
            tick(1);
            scl_m = 0; tick(Q);
        end
        sda_m = !mack; tick(Q);
        scl_m = 1; tick(2 * Q);
        scl_m = 0; tick(Q);
        sda_m = 1;
    endtask

    // T0: reset state
    task automatic t_reset();
        chk(sda_oe == 0, "R1", "sda_oe", sda_oe, 0);
        chk(wr_en == 0, "R1", "wr_en", wr_en, 0);
        chk(rd_req == 0, "R1", "rd_req", rd_req, 0);
        chk(reg_addr == 0, "R1", "reg_addr", reg_addr, 0);
    endtask

    // T1: write burst toggling in pair 6/7
    task automatic t_write_pair();
        bit ack;
        int w0 = wcnt;
        bus_start();
        wbyte(AW, ack);    chk(ack, "R3", "addr ack", ack, 1);
        wbyte(8'h07, ack); chk(ack, "R4", "cmd ack", ack, 1);
        wbyte(8'hA5, ack); chk(ack, "R4", "data ack", ack, 1);
        wbyte(8'h3C, ack);
        wbyte(8'h11, ack);
        bus_stop();
        chk(wcnt - w0 == 3, "R5", "write count", wcnt - w0, 3);
        chk(wl_a[w0] == 7 && wl_d[w0] == 8'hA5, "R5", "write0", {wl_a[w0], wl_d[w0]}, 12'h7A5);
        chk(wl_a[w0+1] == 6 && wl_d[w0+1] == 8'h3C, "R5", "write1", {wl_a[w0+1], wl_d[w0+1]}, 12'h63C);
        chk(wl_a[w0+2] == 7 && wl_d[w0+2] == 8'h11, "R5", "write2", {wl_a[w0+2], wl_d[w0+2]}, 12'h711);
    endtask

    // T2: address mismatch
    task automatic t_mismatch();
        bit ack;
        int w0 = wcnt;
        bus_start();
        wbyte(8'h4C, ack); chk(!ack, "R3", "mismatch ack", ack, 0);
        wbyte(8'h04, ack); chk(!ack, "R3", "after mismatch ack", ack, 0);
        wbyte(8'h99, ack);
        bus_stop();
        chk(wcnt == w0, "R3", "mismatch writes", wcnt - w0, 0);
    endtask

    // T3: no START, plus an SDA glitch while SCL high
    task automatic t_no_start();
        bit ack;
        int w0 = wcnt;
        sda_m = 0; tick(3); sda_m = 1; tick(Q);
        scl_m = 0; tick(Q);
        wbyte(AW, ack);    chk(!ack, "R2", "ack without start", ack, 0);
        chk(!ack, "R10", "sda glitch taken as start", ack, 0);
        wbyte(8'h03, ack);
        wbyte(8'h77, ack);
        scl_m = 1; tick(Q);
        chk(wcnt == w0, "R2", "writes without start", wcnt - w0, 0);
    endtask

    // T4: repeated-start read with ack, ack, nack, then extra clocks
    task automatic t_read_pair();
        bit ack, st;
        logic [7:0] d;
        int r0 = rcnt;
        bus_start();
        wbyte(AW, ack);
        wbyte(8'h02, ack);
        bus_rstart();
        wbyte(AR, ack);        chk(ack, "R3", "read addr ack", ack, 1);
        rbyte(1, d, st);       chk(d == 8'hC2, "R6", "read0", d, 8'hC2);
        chk(st, "R9", "sda stable while scl high", st, 1);
        rbyte(1, d, st);       chk(d == 8'hC3, "R7", "read1", d, 8'hC3);
        rbyte(0, d, st);       chk(d == 8'hC2, "R7", "read2", d, 8'hC2);
        chk(rcnt - r0 == 3, "R6", "rd_req count", rcnt - r0, 3);
        chk(rl_a[r0] == 2 && rl_a[r0+1] == 3 && rl_a[r0+2] == 2, "R7", "fetch addrs",
            {rl_a[r0], rl_a[r0+1], rl_a[r0+2]}, 9'o232);
        rbyte(1, d, st);       chk(d == 8'hFF, "R8", "data after nack", d, 8'hFF);
        chk(rcnt - r0 == 3, "R8", "rd_req after nack", rcnt - r0, 3);
        bus_stop();
    endtask

    // T5: pointer survives STOP
    task automatic t_ptr_kept();
        bit ack, st;
        logic [7:0] d;
        bus_start();
        wbyte(AR, ack);
        rbyte(0, d, st);  chk(d == 8'hC2, "R7", "pointer after stop", d, 8'hC2);
        bus_stop();
    endtask

    // T6: SCL glitch during a write
    task automatic t_scl_glitch();
        bit ack;
        int w0 = wcnt;
        bus_start();
        wbyte(AW, ack);
        wbyte(8'h04, ack);
        scl_m = 1; tick(3); scl_m = 0; tick(Q);
        wbyte(8'h5A, ack);
        bus_stop();
        chk(wcnt - w0 == 1 && wl_a[w0] == 4 && wl_d[w0] == 8'h5A, "R10", "write through scl glitch",
            {wl_a[w0], wl_d[w0]}, 12'h45A);
    endtask

    // T7: STOP mid-byte, command upper bits ignored
    task automatic t_abort();
        bit ack, st;
        logic [7:0] d;
        int w0 = wcnt;
        bus_start();
        wbyte(AW, ack);
        wbyte(8'hF1, ack);
        wbit(1); wbit(0); wbit(1); wbit(1);
        bus_stop();
        chk(wcnt == w0, "R11", "write from partial byte", wcnt - w0, 0);
        bus_start();
        wbyte(AR, ack);
        rbyte(0, d, st);  chk(d == 8'hC1, "R4", "cmd low bits pointer", d, 8'hC1);
        chk(d == 8'hC1, "R11", "pointer kept after abort", d, 8'hC1);
        bus_stop();
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1;
        tick(10);
        t_write_pair();
        t_mismatch();
        t_no_start();
        t_read_pair();
        t_ptr_kept();
        t_scl_glitch();
        t_abort();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule